// File: doc/BRIEF.md
# MDIO Management Command Master

This block is the host-side master for clause-22 style management access to an external PHY over a two-wire MDC/MDIO link. Software controls it through a single command register. That register holds a ready flag, an interrupt-enable choice, an error flag, a two-bit opcode, a five-bit PHY address, a five-bit register address and a sixteen-bit data field. To start an access, the host writes the register with the ready bit clear. The block then builds the serial frame and divides the system clock down to MDC. It drives MDIO, or releases it, as the frame needs. On a read it samples the returned bits. When the access ends, it updates the data and status fields and can raise an interrupt.

The command port is a plain register-write strobe, not a stream, so it has no back-pressure. A write that arrives while an access is in flight is dropped. The host is expected to poll `stat_ready` or wait for `irq` before it issues the next command. The MDIO pad is split into output, output-enable and input, and the pad cell and pull-up sit outside the block.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the ready flag is 1, the error flag is 0, `irq` is 0, MDC is low and MDIO is released (`mdio_oe` = 0).
- R2: A command is taken only when `cmd_we` is high, the written ready bit `cmd_rdy` is 0 and `stat_ready` is 1. Taking a command clears ready, error and `irq` on the following cycle.
- R3: Opcode 01 is a write. It drives 64 bits on MDIO, most significant first: 32 ones, then start 01, opcode 01, PHY address, register address, turnaround 10 and the 16 data bits. The access uses 64 rising MDC edges and leaves the data field holding the written value.
- R4: Opcode 10 is a read. It drives only the first 46 bits: 32 ones, then 01, 10, PHY address and register address. It then releases MDIO and samples the 16 data bits on rising MDC, most significant first. On completion the data field holds those bits and the error flag is 0.
- R5: MDIO output changes only while MDC is low, that is, after a falling MDC edge.
- R6: Each MDC phase lasts `DIV_HALF` system clocks, so MDC has a period of 4 clocks by default. MDC stays low when no access is running.
- R7: Opcodes 00 and 11 are invalid. They produce no MDC edge and never drive MDIO. The block sets ready and error, and the data field keeps the written value.
- R8: On a read, if MDIO is not 0 at the rising edge of the second turnaround bit, the access stops after that edge (48 rising edges in total). The block then sets error, loads 0xFFFF into the data field and sets ready.
- R9: `irq` is a level. It goes high when a command completes with its interrupt enable set, and it stays high until the next command is taken. It never rises for a command whose enable is clear.
- R10: A command write made while ready is 0 is ignored. The running frame, its result and its interrupt choice are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_rdy | input | 1 | Ready bit value written (must be 0 to start) |
| cmd_ie | input | 1 | Interrupt enable for this command |
| cmd_op | input | 2 | Opcode: 01 write, 10 read, others invalid |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_data | input | 16 | Write data |
| stat_ready | output | 1 | Ready flag (1 = idle / done) |
| stat_err | output | 1 | Error flag |
| stat_ie | output | 1 | Interrupt enable of the last command |
| stat_data | output | 16 | Data field (write data or read result) |
| irq | output | 1 | Completion interrupt, level |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions take three things for granted. The command inputs matter only in the cycle `cmd_we` is high. `DIV_HALF` is at least 2, so the sequencer always sees a falling edge before the next rising one. `mdio_i` changes only while MDC is low. The bench keeps to these limits by pulsing `cmd_we` for exactly one clock and by updating its PHY model's MDIO only on falling MDC. It also keeps the default divider.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam int HDR_BITS = 32;      // start, op, two addresses, turnaround, data
  localparam int TA_HI_IDX = 17;     // frame index of first turnaround bit
  localparam int TA_LO_IDX = 16;     // frame index of second turnaround bit
  localparam int DATA_W = 16;

  function automatic logic op_is_valid(input logic [1:0] op);
    return (op == OP_WR) || (op == OP_RD);
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(DIV_HALF + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
      rise  <= 1'b0;
      fall  <= 1'b0;
    end else if (cnt_q == CW'(DIV_HALF - 1)) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
      rise  <= ~mdc;
      fall  <= mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      rise  <= 1'b0;
      fall  <= 1'b0;
    end
  end

  // MDC only moves while the sequencer had it enabled
  assert_mdc_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && !$past(mdc)) |-> $past(en));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int DIV_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [4:0]        phy,
  input  logic [4:0]        regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              abort,
  output logic              rd_flag,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FRAME = PRE_BITS + HDR_BITS;
  localparam int IW    = $clog2(FRAME);

  logic             busy_q;
  logic [IW-1:0]    idx_q;
  logic [FRAME-1:0] frame_q;
  logic             rise, fall;

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(busy_q), .mdc(mdc), .rise(rise), .fall(fall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      frame_q <= '0;
      rd_flag <= 1'b0;
      rd_data <= '0;
      done    <= 1'b0;
      abort   <= 1'b0;
    end else begin
      done  <= 1'b0;
      abort <= 1'b0;
      if (start && !busy_q) begin
        busy_q  <= 1'b1;
        idx_q   <= IW'(FRAME - 1);
        frame_q <= {{PRE_BITS{1'b1}}, 2'b01, op, phy, regad, 2'b10, wdata};
        rd_flag <= (op == OP_RD);
        rd_data <= '0;
      end else if (busy_q) begin
        if (rise && rd_flag) begin
          if (idx_q == IW'(TA_LO_IDX) && mdio_i) begin
            busy_q <= 1'b0;
            done   <= 1'b1;
            abort  <= 1'b1;
          end else if (idx_q < IW'(TA_LO_IDX)) begin
            rd_data <= {rd_data[DATA_W-2:0], mdio_i};
          end
        end
        if (fall) begin
          if (idx_q == '0) begin
            busy_q <= 1'b0;
            done   <= 1'b1;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
      end
    end
  end

  assign mdio_oe = busy_q && (!rd_flag || idx_q > IW'(TA_HI_IDX));
  assign mdio_o  = busy_q && frame_q[idx_q];

  // MDIO value only moves in the low half of MDC
  assert_mdio_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && mdio_o != $past(mdio_o)) |-> !mdc);
  // a read never drives the bus during turnaround or data
  assert_read_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_flag && rise && idx_q <= IW'(TA_HI_IDX)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic        cmd_rdy,
  input  logic        cmd_ie,
  input  logic [1:0]  cmd_op,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_data,
  output logic        stat_ready,
  output logic        stat_err,
  output logic        stat_ie,
  output logic [15:0] stat_data,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              accept, go;
  logic              bad_q;
  logic              seq_done, seq_abort, seq_rd;
  logic [DATA_W-1:0] seq_rdata;

  assign accept = cmd_we && stat_ready && !cmd_rdy;
  assign go     = accept && op_is_valid(cmd_op);

  mdio_frame_seq #(.PRE_BITS(PRE_BITS), .DIV_HALF(DIV_HALF)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(go), .op(cmd_op), .phy(cmd_phy),
    .regad(cmd_reg), .wdata(cmd_data), .mdio_i(mdio_i), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(seq_done), .abort(seq_abort),
    .rd_flag(seq_rd), .rd_data(seq_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_ready <= 1'b1;
      stat_err   <= 1'b0;
      stat_ie    <= 1'b0;
      stat_data  <= '0;
      irq        <= 1'b0;
      bad_q      <= 1'b0;
    end else begin
      bad_q <= 1'b0;
      if (accept) begin
        stat_ready <= 1'b0;
        stat_err   <= 1'b0;
        irq        <= 1'b0;
        stat_ie    <= cmd_ie;
        stat_data  <= cmd_data;
        bad_q      <= !op_is_valid(cmd_op);
      end else if (bad_q) begin
        stat_ready <= 1'b1;
        stat_err   <= 1'b1;
        irq        <= stat_ie;
      end else if (seq_done) begin
        stat_ready <= 1'b1;
        stat_err   <= seq_abort;
        irq        <= stat_ie;
        if (seq_abort)   stat_data <= 16'hFFFF;
        else if (seq_rd) stat_data <= seq_rdata;
      end
    end
  end

  assert_accept_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!stat_ready && !stat_err && !irq));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ready |-> (!mdio_oe && !mdc));
  assert_abort_ffff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && seq_abort) |=> (stat_ready && stat_err && stat_data == 16'hFFFF));
  assert_irq_needs_ie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_ready && stat_ie));
  assert_busy_write_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_ready && cmd_we && !seq_done && !bad_q) |=> ($stable(stat_data) && $stable(stat_ie)));
endmodule

// File: tb/test_mdio_cmd_master.sv
module test_mdio_cmd_master;
  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] data;
    logic        ie;
    logic        ack;
    logic [15:0] rdat;
    logic        eerr;
    logic [15:0] edata;
    logic [6:0]  erises;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{2'b01, 5'h01, 5'h00, 16'hA5C3, 1'b1, 1'b1, 16'h0000, 1'b0, 16'hA5C3, 7'd64},
    '{2'b10, 5'h1F, 5'h1F, 16'h0000, 1'b0, 1'b1, 16'h1234, 1'b0, 16'h1234, 7'd64},
    '{2'b10, 5'h00, 5'h02, 16'h0000, 1'b1, 1'b0, 16'h5555, 1'b1, 16'hFFFF, 7'd48},
    '{2'b00, 5'h04, 5'h05, 16'hBEEF, 1'b1, 1'b1, 16'h0000, 1'b1, 16'hBEEF, 7'd0},
    '{2'b11, 5'h06, 5'h07, 16'h0011, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0011, 7'd0},
    '{2'b01, 5'h10, 5'h15, 16'h8001, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h8001, 7'd64},
    '{2'b10, 5'h0A, 5'h11, 16'h0000, 1'b1, 1'b1, 16'h8001, 1'b0, 16'h8001, 7'd64}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0, cmd_rdy = 1'b0, cmd_ie = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [4:0] cmd_phy = '0, cmd_reg = '0;
  logic [15:0] cmd_data = '0;
  logic stat_ready, stat_err, stat_ie, irq, mdc, mdio_o, mdio_oe;
  logic [15:0] stat_data;
  logic phy_drv = 1'b1;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mdio_cmd_master i_mdio_cmd_master (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_rdy(cmd_rdy), .cmd_ie(cmd_ie),
    .cmd_op(cmd_op), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .stat_ready(stat_ready), .stat_err(stat_err), .stat_ie(stat_ie),
    .stat_data(stat_data), .irq(irq), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(phy_drv)
  );

  // PHY model: records driven bits, answers reads
  int rises = 0;
  int ndrv = 0;
  logic [63:0] cap = '0;
  time t_last = 0, t_prev = 0;
  int base_r = 0;
  logic ph_ack = 1'b1;
  logic [15:0] ph_data = '0;

  always @(posedge mdc) begin
    if (mdio_oe) begin
      cap  = {cap[62:0], mdio_o};
      ndrv = ndrv + 1;
    end
    rises  = rises + 1;
    t_prev = t_last;
    t_last = $time;
  end

  always @(negedge mdc) begin
    int n;
    n = rises - base_r;
    if (n == 47)                phy_drv = ph_ack ? 1'b0 : 1'b1;
    else if (n >= 48 && n < 64) phy_drv = ph_data[63-n];
    else                        phy_drv = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic rdyb, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] d, input logic ie);
    @(negedge clk);
    cmd_we = 1'b1; cmd_rdy = rdyb; cmd_op = op; cmd_phy = phy;
    cmd_reg = rg; cmd_data = d; cmd_ie = ie;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_ready(output logic ok);
    ok = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      if (stat_ready) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end

  initial begin
    logic ok;
    int r0, d0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", stat_ready, 1);
    chk("R1 err", stat_err, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mdc/oe", {mdc, mdio_oe}, 0);

    for (int v = 0; v < NV; v++) begin
      ph_ack = VT[v].ack; ph_data = VT[v].rdat;
      base_r = rises; r0 = rises; d0 = ndrv;
      issue(1'b0, VT[v].op, VT[v].phy, VT[v].rg, VT[v].data, VT[v].ie);
      // R2: accept clears flags
      chk("R2 busy after accept", {stat_ready, stat_err, irq}, 0);
      wait_ready(ok);
      chk("R2 completed", ok, 1);
      repeat (2) @(negedge clk);
      chk(VT[v].eerr ? "R8/R7 err set" : "R4/R3 err clear", stat_err, VT[v].eerr);
      chk(VT[v].erises == 48 ? "R8 data FFFF" : "R3/R4/R7 data", stat_data, VT[v].edata);
      chk("R9 irq level", irq, VT[v].ie);
      chk("R8/R7/R3 MDC edges", rises - r0, VT[v].erises);
      if (VT[v].op == 2'b01) begin
        chk("R3 drive count", ndrv - d0, 64);
        chk("R3 frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, VT[v].phy, VT[v].rg, 2'b10, VT[v].data});
      end else if (VT[v].op == 2'b10) begin
        chk("R4 drive count", ndrv - d0, 46);
        chk("R4 header", cap[45:0], {32'hFFFF_FFFF, 2'b01, 2'b10, VT[v].phy, VT[v].rg});
      end else begin
        chk("R7 no drive", ndrv - d0, 0);
      end
      if (v == 0) chk("R6 MDC period", t_last - t_prev, 80);
      chk("R6 mdc idle low", mdc, 0);
    end

    // R10: write during busy ignored
    ph_ack = 1'b1; base_r = rises; r0 = rises; d0 = ndrv;
    issue(1'b0, 2'b01, 5'h03, 5'h04, 16'h1111, 1'b0);
    repeat (20) @(negedge clk);
    issue(1'b0, 2'b01, 5'h1C, 5'h1B, 16'h2222, 1'b1);
    wait_ready(ok);
    repeat (2) @(negedge clk);
    chk("R10 data kept", stat_data, 16'h1111);
    chk("R10 frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h1111});
    chk("R10 single frame", rises - r0, 64);
    chk("R10 irq choice kept", irq, 0);

    // R2: written ready bit set -> no command
    r0 = rises;
    issue(1'b1, 2'b01, 5'h02, 5'h02, 16'h7777, 1'b1);
    repeat (10) @(negedge clk);
    chk("R2 rdy bit set ignored ready", stat_ready, 1);
    chk("R2 rdy bit set ignored data", stat_data, 16'h1111);
    chk("R2 rdy bit set no mdc", rises - r0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule